// File: doc/BRIEF.md
# Parallel Fixed-Length Codeword Expander

This block turns a stream of compressed words back into the original bit stream when the compression used a variable-to-fixed code. Each compressed word carries K fixed-width codewords of N bits. Every codeword names one leaf of a parsing tree, and each leaf stands for a source bit string of 0 to L bits. No codeword depends on the one before it, so the block looks up all K codewords of a word in the same cycle, in one shared table. It places the K expansions back to back by adding up their lengths, and appends the result to an output buffer. The buffer sends the stream out as 32-bit words.

Compressed blocks are handled one at a time. The first input word of a block carries the block's true source length. Bits that the encoder added at the end of the block are dropped. These are bits that complete the last tree leaf, or whole filler codewords that pad the block to a byte boundary. After the last input word the buffer is drained. The final, partly filled word is marked and carries its bit count, so the next block always starts at bit 0 of a fresh word.

The table is written through a separate load port, one entry per cycle. Software fills it before decoding.

Top module: `v2f_par_decoder`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, and every table entry has length 0, so words decoded before any load produce no output bits.
- R2: With `cb_we` high, the entry at `cb_addr` takes length `cb_len` (0..L) and bit string `cb_bits`, with `cb_bits[0]` as the first source bit. Words accepted in the same cycle as the write still use the old entry. Words accepted in later cycles use the new one.
- R3: Lane j of a word is `in_data[4j+3:4j]` with the default N=4, and lane 0 comes first. The expansions of lanes 0..K-1 are joined in lane order with no gaps. Stream bit i of an output word is `out_data[i]`.
- R4: Every output word that is not the last of its block holds exactly 32 stream bits, and reports `out_nbits` = 32.
- R5: `blk_len` is sampled with the word that has `in_first` = 1. Only the first `blk_len` decoded bits of the block are output. The rest are discarded, including all bits from filler codewords.
- R6: The last output word of a block has `out_last` = 1. Its `out_nbits` is from 1 to 32 and its unused high bits are 0. The first bit of the next block appears at `out_data[0]` of a new word.
- R7: While `out_valid` is 1 and `out_ready` is 0, the output word, its count and its last flag stay unchanged. `in_ready` is 0 whenever an output word is pending.
- R8: A codeword whose entry has length 0 adds no bits. The lanes after it close the gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cb_we | input | 1 | Table write strobe |
| cb_addr | input | N | Table entry written |
| cb_len | input | $clog2(L+1) | Expansion length of the entry |
| cb_bits | input | L | Expansion bits, bit 0 first |
| in_valid | input | 1 | Compressed word present |
| in_ready | output | 1 | Compressed word accepted this cycle when valid |
| in_data | input | K*N | K codewords, lane 0 in the low bits |
| in_first | input | 1 | Word opens a block |
| in_last | input | 1 | Word closes a block |
| blk_len | input | LENW | Source bit count of the block, sampled with in_first |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Sink takes the output word |
| out_data | output | OW | Decoded stream bits, first bit in bit 0 |
| out_nbits | output | $clog2(OW+1) | Valid bits in out_data |
| out_last | output | 1 | Final word of the block |

## Verification
The bench compares the output bit for bit against a serial model. The model expands one codeword at a time and then cuts the result to the block length. If the lane offsets were summed wrongly, or if lanes were joined in the wrong order, the stream would show shifted or swapped segments. Blocks are cut in the middle of a codeword and have filler codewords at the end. A design that ignored the block length would send extra bits, and one that cut at codeword boundaries would send the wrong count. Table entries of length zero and stored bits above the entry length check the masking: stray high bits would OR into the next lane. The bench also rewrites an entry in the same cycle as a word that uses it. A slow sink checks that a held word stays unchanged. Back-to-back blocks show whether leftover bits leak into the next block's first word.

// File: rtl/v2f_par_decoder.sv
module v2f_par_decoder #(
  parameter int N    = 4,
  parameter int K    = 4,
  parameter int L    = 8,
  parameter int OW   = 32,
  parameter int LENW = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cb_we,
  input  logic [N-1:0]             cb_addr,
  input  logic [$clog2(L+1)-1:0]   cb_len,
  input  logic [L-1:0]             cb_bits,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [K*N-1:0]           in_data,
  input  logic                     in_first,
  input  logic                     in_last,
  input  logic [LENW-1:0]          blk_len,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [OW-1:0]            out_data,
  output logic [$clog2(OW+1)-1:0]  out_nbits,
  output logic                     out_last
);
  localparam int E   = 1 << N;
  localparam int LW  = $clog2(L+1);
  localparam int MW  = K * L;
  localparam int SW  = $clog2(MW+1);
  localparam int BW  = 2 * OW;
  localparam int CW  = $clog2(BW+1);
  localparam int OBW = $clog2(OW+1);

  logic [L-1:0]    mem_bits [E];
  logic [LW-1:0]   mem_len  [E];
  logic [BW-1:0]   acc;
  logic [CW-1:0]   cnt;
  logic [LENW-1:0] rem;
  logic            fl;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < E; i++) mem_len[i] <= '0;
    end else if (cb_we) begin
      mem_len[cb_addr] <= cb_len;
    end
  end

  always_ff @(posedge clk)
    if (cb_we) mem_bits[cb_addr] <= cb_bits;

  logic [LW-1:0] ln  [K];
  logic [MW-1:0] lb  [K];
  logic [SW-1:0] off [K+1];
  assign off[0] = '0;

  for (genvar k = 0; k < K; k++) begin : g_lane
    logic [N-1:0] cw;
    logic [L:0]   one_sh;
    logic [L-1:0] bits;
    assign cw        = in_data[k*N +: N];
    assign ln[k]     = mem_len[cw];
    assign one_sh    = (L+1)'(1) << ln[k];
    assign bits      = mem_bits[cw] & L'(one_sh - 1'b1);
    assign lb[k]     = MW'(bits) << off[k];
    assign off[k+1]  = off[k] + SW'(ln[k]);
  end

  logic [MW-1:0] merged;
  always_comb begin
    merged = '0;
    for (int k = 0; k < K; k++) merged = merged | lb[k];
  end

  logic [LENW-1:0] rem_base, nl_ext, take_w;
  logic [SW-1:0]   take;
  logic [MW:0]     tk_sh;
  logic [MW-1:0]   kept;
  assign rem_base = in_first ? blk_len : rem;
  assign nl_ext   = LENW'(off[K]);
  assign take_w   = (nl_ext < rem_base) ? nl_ext : rem_base;
  assign take     = SW'(take_w);
  assign tk_sh    = (MW+1)'(1) << take;
  assign kept     = merged & MW'(tk_sh - 1'b1);

  assign in_ready  = !fl && (cnt <= CW'(OW));
  assign out_valid = (cnt > CW'(OW)) || (fl && cnt != '0);
  assign out_last  = fl && (cnt <= CW'(OW));
  assign out_nbits = out_last ? cnt[OBW-1:0] : OBW'(OW);
  assign out_data  = acc[OW-1:0];

  wire in_fire  = in_valid && in_ready;
  wire out_fire = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      cnt <= '0;
      rem <= '0;
      fl  <= 1'b0;
    end else if (in_fire) begin
      acc <= acc | (BW'(kept) << cnt);
      cnt <= cnt + CW'(take);
      rem <= rem_base - take_w;
      fl  <= in_last;
    end else if (fl && cnt == '0) begin
      fl <= 1'b0;
    end else if (out_fire) begin
      if (out_last) begin
        acc <= '0;
        cnt <= '0;
        fl  <= 1'b0;
      end else begin
        acc <= acc >> OW;
        cnt <= cnt - CW'(OW);
      end
    end
  end
endmodule

// File: rtl/v2f_par_decoder_chk.sv
module v2f_par_decoder_chk #(
  parameter int OW = 32
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [OW-1:0]           out_data,
  input logic [$clog2(OW+1)-1:0] out_nbits,
  input logic                    out_last
);
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (in_ready && !out_valid));

  a_r7_hold_out: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                   $stable(out_nbits) && $stable(out_last)));

  a_r7_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid));

  a_r4_full_word: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last) |-> (out_nbits == ($clog2(OW+1))'(OW)));

  a_r6_tail_clean: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_nbits != '0) && ((out_data >> out_nbits) == '0)));
endmodule

bind v2f_par_decoder v2f_par_decoder_chk #(.OW(OW)) chk_i (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_nbits(out_nbits),
  .out_last(out_last)
);

// File: tb/v2f_par_decoder_tb_top.sv
`timescale 1ns/1ps
module v2f_par_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cb_we = 1'b0;
  logic [3:0]  cb_addr = '0;
  logic [3:0]  cb_len = '0;
  logic [7:0]  cb_bits = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        in_first = 1'b0;
  logic        in_last = 1'b0;
  logic [15:0] blk_len = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic [5:0]  out_nbits;
  logic        out_last;

  always #4 clk = ~clk;

  v2f_par_decoder dut_i (
    .clk(clk), .rst(rst), .cb_we(cb_we), .cb_addr(cb_addr), .cb_len(cb_len),
    .cb_bits(cb_bits), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_first(in_first), .in_last(in_last),
    .blk_len(blk_len), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_nbits(out_nbits), .out_last(out_last)
  );

  int total = 0, bad = 0;
  logic [7:0] rb [16];
  int rl [16];
  logic [15:0] wq [$];
  bit exp_q [$];
  bit got_q [$];
  int lasts = 0, lasts_exp = 0;
  int bp_mode = 0, cyc = 0;
  int nonfull_err = 0, tail_err = 0, hold_err = 0;
  bit pend = 0;
  logic [31:0] hd;
  logic [5:0] hn;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=1 expected=0");
    summary();
    $finish;
  end

  initial forever begin
    @(negedge clk);
    cyc++;
    out_ready = (bp_mode == 0) ? 1'b1 : (cyc % 3 == 0);
    if (pend && (!out_valid || out_data != hd || out_nbits != hn)) hold_err++;
    pend = 0;
    if (out_valid) begin
      if (out_ready) begin
        for (int b = 0; b < out_nbits; b++) got_q.push_back(out_data[b]);
        if (!out_last && out_nbits != 6'd32) nonfull_err++;
        if ((out_data >> out_nbits) != 0) tail_err++;
        if (out_last) lasts++;
      end else begin
        pend = 1; hd = out_data; hn = out_nbits;
      end
    end
  end

  task automatic load(input int a, input int len, input logic [7:0] bits);
    @(negedge clk);
    cb_we = 1; cb_addr = 4'(a); cb_len = 4'(len); cb_bits = bits;
    rb[a] = bits; rl[a] = len;
    @(negedge clk);
    cb_we = 0;
  endtask

  task automatic expand(input logic [15:0] w);
    for (int k = 0; k < 4; k++) begin
      int c = int'(w[4*k +: 4]);
      for (int b = 0; b < rl[c]; b++) exp_q.push_back(rb[c][b]);
    end
  endtask

  task automatic feed(input int blen);
    for (int i = 0; i < wq.size(); i++) begin
      @(negedge clk);
      in_valid = 1; in_data = wq[i]; blk_len = 16'(blen);
      in_first = (i == 0); in_last = (i == wq.size() - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 0; in_first = 0; in_last = 0;
  endtask

  task automatic finish_check(input int blen, input string req);
    int t = 0, mism = 0, first_bad = -1;
    foreach (wq[i]) expand(wq[i]);
    while (exp_q.size() > blen) void'(exp_q.pop_back());
    if (exp_q.size() > 0) lasts_exp++;
    while (lasts < lasts_exp && t < 3000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
    chk(lasts == lasts_exp, {req, " R6 last word seen"}, lasts, lasts_exp);
    chk(got_q.size() == exp_q.size(), {req, " R5 bit count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
      if (got_q[i] != exp_q[i]) begin mism++; if (first_bad < 0) first_bad = i; end
    chk(mism == 0, {req, " R3 stream bits, first bad index"}, first_bad, -1);
    chk(nonfull_err == 0 && tail_err == 0, {req, " R4 R6 word format"},
        nonfull_err + tail_err, 0);
    chk(hold_err == 0, {req, " R7 hold while stalled"}, hold_err, 0);
    chk(in_ready == 1'b1, {req, " R6 ready for next block"}, in_ready, 1);
    got_q.delete(); exp_q.delete(); wq.delete();
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
    for (int a = 0; a < 16; a++) begin rl[a] = 0; rb[a] = '0; end
    wq.push_back(16'h3A51);
    feed(20);
    repeat (10) @(negedge clk);
    chk(got_q.size() == 0 && lasts == 0, "R1 empty table yields no bits", got_q.size(), 0);
    chk(in_ready == 1'b1, "R1 block closes with no output", in_ready, 1);
    wq.delete();
  endtask

  task automatic t_fill_table();
    for (int a = 0; a < 16; a++) load(a, (a * 5 + 3) % 9, 8'(a * 8'h5B) ^ 8'hA6);
  endtask

  task automatic t_mixed();
    logic [15:0] w = 16'h1F2E;
    for (int i = 0; i < 12; i++) begin
      wq.push_back(w);
      w = {w[14:0], w[15] ^ w[13] ^ w[12] ^ w[10]};
    end
    feed(65535);
    finish_check(65535, "R2 R3 mixed lanes");
  endtask

  task automatic t_truncate();
    wq.push_back(16'h8765); wq.push_back(16'h4321); wq.push_back(16'hFFF9);
    feed(31);
    finish_check(31, "R5 cut mid-codeword with filler");
  endtask

  task automatic t_zero_len();
    wq.push_back(16'h3C3C); wq.push_back(16'h5333); wq.push_back(16'hC1C2);
    feed(65535);
    finish_check(65535, "R8 zero-length entries");
  endtask

  task automatic t_backpressure();
    bp_mode = 1;
    for (int i = 0; i < 40; i++) wq.push_back(16'(i * 16'h9E37 + 16'h7F4A));
    feed(65535);
    finish_check(65535, "R4 R7 slow sink");
    bp_mode = 0;
  endtask

  task automatic t_reload();
    logic [7:0] nb = 8'h96;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    cb_we = 1; cb_addr = 4'd6; cb_len = 4'd7; cb_bits = nb;
    in_valid = 1; in_data = 16'h6666; in_first = 1; in_last = 0; blk_len = 16'd65535;
    expand(16'h6666);
    @(negedge clk);
    rb[6] = nb; rl[6] = 7;
    cb_we = 0;
    in_data = 16'h6666; in_first = 0; in_last = 1;
    while (!in_ready) @(negedge clk);
    expand(16'h6666);
    @(negedge clk);
    in_valid = 0; in_last = 0;
    finish_check(65535, "R2 write visible next cycle");
  endtask

  task automatic t_two_blocks();
    wq.push_back(16'hABCD); wq.push_back(16'h0F1E); wq.push_back(16'h2D3C);
    feed(37);
    finish_check(37, "R6 block A");
    wq.push_back(16'h9A8B); wq.push_back(16'h7C6D);
    feed(19);
    finish_check(19, "R6 block B fresh start");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_fill_table();
    t_mixed();
    t_truncate();
    t_zero_len();
    t_backpressure();
    t_reload();
    t_two_blocks();
    summary();
    $finish;
  end
endmodule